// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripheral DMA request lines and the host processor's bus hold handshake. When any unmasked channel requests service, it raises a hold request. Once the processor answers with hold acknowledge, it grants the bus to the highest-priority pending channel. For the granted channel it drives an active-low acknowledge line, and it hands the channel index and a per-byte transfer strobe to an external address and data path.

Each channel has a two-bit service mode. In single service one byte moves and the bus is then returned. In block service bytes move on every cycle until the datapath flags terminal count or an external end-of-process arrives. In demand service bytes move while the peripheral keeps its request high. Terminal count and end-of-process are simple inputs from the datapath and the system. Masks, modes and requests are synchronous to the controller clock.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `rst_n` is low, `hrq` is low, all of `dack_n` are high and `xfer_stb` is low.
- R2: A pending request is a `dreq` bit whose `chan_mask` bit is 0. One from idle raises `hrq` on the next clock edge.
- R3: No acknowledge or strobe is given while `hlda` is low. At the first edge where `hlda` is high during the hold request, the lowest-numbered pending channel wins (channel 0 highest priority).
- R4: A channel whose `chan_mask` bit is 1 is ignored. Its request alone does not raise `hrq`, and it never wins the grant.
- R5: During a grant exactly one `dack_n` bit, the winner's, is low. Each `xfer_stb` pulse marks one byte for the channel shown on `xfer_chan`.
- R6: `chan_mode[2i+1:2i]` selects channel i's mode: 00 single, 01 block, 10 demand, 11 behaves as single. In single mode exactly one strobe is given per grant and the bus is then released.
- R7: In block mode a strobe is given on every granted cycle. The strobe on which `tc` or `eop_ext` is high is the last one.
- R8: In demand mode strobes continue while the channel's `dreq` is high. A granted cycle with `dreq` low gives no strobe and ends the service. A strobe with `tc` high also ends it.
- R9: `hrq` falls on the edge after the last transfer. No new hold request is raised until `hlda` has been seen low.
- R10: If `hlda` falls during a grant, all `dack_n` go high and the strobe stops in that same cycle. `hrq` stays high, and service resumes when `hlda` returns.
- R11: If every pending request disappears while the hold request is waiting for `hlda`, `hrq` is dropped on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | 4 | Peripheral request lines, bit 0 highest priority |
| chan_mask | input | 4 | 1 removes the channel from arbitration |
| chan_mode | input | 8 | Two-bit service mode per channel |
| hlda | input | 1 | Hold acknowledge from the processor |
| tc | input | 1 | Terminal count from the datapath, qualifies the current byte |
| eop_ext | input | 1 | External end-of-process, qualifies the current byte |
| hrq | output | 1 | Hold request to the processor |
| dack_n | output | 4 | Active-low per-channel acknowledge |
| xfer_stb | output | 1 | One byte is transferred this cycle |
| xfer_chan | output | 2 | Index of the channel being served |

## Verification
A wrong control state shows at the ports within one clock. A stuck service state keeps `hrq` high after a single-mode byte. A lost hold request leaves `hrq` low while a request waits. A misdecoded winner pulls the wrong `dack_n` bit low on the first granted cycle. Because acknowledge is gated by `hlda` without a register, a broken abort path shows in the same cycle that `hlda` falls. Demand and block endings appear as an extra or a missing strobe exactly one cycle after the ending condition.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    SVC_SINGLE = 2'd0,
    SVC_BLOCK  = 2'd1,
    SVC_DEMAND = 2'd2,
    SVC_SPARE  = 2'd3
  } svc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD_REQ,
    ST_SERVE,
    ST_RELEASE
  } arb_state_e;

  // A byte closes the service when the mode is single-shot or an end flag is up.
  function automatic logic byte_is_last(svc_mode_e m, logic tc, logic eop);
    return ((m != SVC_BLOCK) && (m != SVC_DEMAND)) || tc || eop;
  endfunction

  // Demand service lapses as soon as the peripheral withdraws its request.
  function automatic logic demand_lapsed(svc_mode_e m, logic req);
    return (m == SVC_DEMAND) && !req;
  endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend,
  output logic           any,
  output logic [IW-1:0]  idx
);

  logic [NCH:0]   seen;
  logic [NCH-1:0] sel;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign sel[i]      = pend[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | pend[i];
  end

  assign any = seen[NCH];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_any,
  input  logic [IW-1:0] pick_idx,
  input  logic          hlda,
  input  logic          req_win,
  input  svc_mode_e     mode_win,
  input  logic          tc,
  input  logic          eop_ext,
  output logic [IW-1:0] chan,
  output logic          hrq,
  output logic          grant_on,
  output logic          xfer_stb,
  output logic          xfer_done
);

  arb_state_e state, state_nx;
  logic       lapsed;

  assign grant_on  = (state == ST_SERVE) && hlda;
  assign lapsed    = demand_lapsed(mode_win, req_win);
  assign xfer_stb  = grant_on && !lapsed;
  assign xfer_done = grant_on && (lapsed || byte_is_last(mode_win, tc, eop_ext));
  assign hrq       = (state == ST_HOLD_REQ) || (state == ST_SERVE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (pend_any) state_nx = ST_HOLD_REQ;
      ST_HOLD_REQ: begin
        if (!pend_any)  state_nx = ST_RELEASE;
        else if (hlda)  state_nx = ST_SERVE;
      end
      ST_SERVE: begin
        if (!hlda)          state_nx = ST_HOLD_REQ;
        else if (xfer_done) state_nx = ST_RELEASE;
      end
      ST_RELEASE:  if (!hlda) state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      chan  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_HOLD_REQ && pend_any && hlda) chan <= pick_idx;
    end
  end

endmodule

// File: rtl/dma_ack_drive.sv
module dma_ack_drive #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           grant_on,
  input  logic [IW-1:0]  chan,
  output logic [NCH-1:0] dack_n
);

  for (genvar i = 0; i < NCH; i++) begin : g_ack
    assign dack_n[i] = ~(grant_on && (chan == IW'(i)));
  end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] chan_mask,
  input  logic [MW-1:0]  chan_mode,
  input  logic           hlda,
  input  logic           tc,
  input  logic           eop_ext,
  output logic           hrq,
  output logic [NCH-1:0] dack_n,
  output logic           xfer_stb,
  output logic [IW-1:0]  xfer_chan
);

  logic [NCH-1:0] pend;
  logic           pend_any;
  logic [IW-1:0]  pick_idx;
  logic [IW-1:0]  chan;
  logic           grant_on;
  logic           xfer_done;
  logic           req_win;
  svc_mode_e      mode_win;

  assign pend      = dreq & ~chan_mask;
  assign req_win   = dreq[chan];
  assign mode_win  = svc_mode_e'(chan_mode[2*chan +: 2]);
  assign xfer_chan = chan;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .pend (pend),
    .any  (pend_any),
    .idx  (pick_idx)
  );

  dma_arb_ctrl #(.NCH(NCH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_any  (pend_any),
    .pick_idx  (pick_idx),
    .hlda      (hlda),
    .req_win   (req_win),
    .mode_win  (mode_win),
    .tc        (tc),
    .eop_ext   (eop_ext),
    .chan      (chan),
    .hrq       (hrq),
    .grant_on  (grant_on),
    .xfer_stb  (xfer_stb),
    .xfer_done (xfer_done)
  );

  dma_ack_drive #(.NCH(NCH)) u_ack (
    .grant_on (grant_on),
    .chan     (chan),
    .dack_n   (dack_n)
  );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MW = 2 * NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic [MW-1:0]  chan_mode,
  input logic           hlda,
  input logic           hrq,
  input logic [NCH-1:0] dack_n,
  input logic           xfer_stb,
  input logic [IW-1:0]  xfer_chan,
  input logic           xfer_done
);

  logic stb_single;
  assign stb_single = xfer_stb && ((chan_mode[2*xfer_chan +: 2] == 2'd0) ||
                                   (chan_mode[2*xfer_chan +: 2] == 2'd3));

  a_r5_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dack_n) <= 1);

  a_r3_ack_needs_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda |-> (&dack_n && !xfer_stb));

  a_r5_stb_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> (!dack_n[xfer_chan] && hrq));

  a_r9_hrq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !hrq);

  a_r9_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (!hrq && hlda) |=> !xfer_stb);

  a_r6_single_once: assert property (@(posedge clk) disable iff (!rst_n)
    stb_single |=> !xfer_stb);

  a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hrq && !hlda && $past(xfer_stb)) |-> &dack_n);

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_mode (chan_mode),
  .hlda      (hlda),
  .hrq       (hrq),
  .dack_n    (dack_n),
  .xfer_stb  (xfer_stb),
  .xfer_chan (xfer_chan),
  .xfer_done (xfer_done)
);

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dreq = '0;
  logic [3:0] chan_mask = '0;
  logic [7:0] chan_mode = '0;
  logic       hlda = 1'b0;
  logic       tc = 1'b0;
  logic       eop_ext = 1'b0;
  logic       hrq;
  logic [3:0] dack_n;
  logic       xfer_stb;
  logic [1:0] xfer_chan;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk (clk), .rst_n (rst_n), .dreq (dreq), .chan_mask (chan_mask),
    .chan_mode (chan_mode), .hlda (hlda), .tc (tc), .eop_ext (eop_ext),
    .hrq (hrq), .dack_n (dack_n), .xfer_stb (xfer_stb), .xfer_chan (xfer_chan)
  );

  // {mode8, dreq4, mask4, hlda, tc, eop, | exp hrq, exp dack_n4, exp stb, exp chan2}
  localparam int NV = 41;
  localparam logic [26:0] VEC [NV] = '{
    {8'h00,4'b0110,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0110,4'b0000,3'b000, 1'b1,4'b1111,1'b0,2'd0},
    {8'h00,4'b0110,4'b0000,3'b100, 1'b1,4'b1111,1'b0,2'd0},
    {8'h00,4'b0110,4'b0000,3'b100, 1'b1,4'b1101,1'b1,2'd1},
    {8'h00,4'b0100,4'b0000,3'b100, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0100,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0100,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0100,4'b0000,3'b000, 1'b1,4'b1111,1'b0,2'd0},
    {8'h00,4'b0100,4'b0000,3'b100, 1'b1,4'b1111,1'b0,2'd0},
    {8'h00,4'b0100,4'b0000,3'b100, 1'b1,4'b1011,1'b1,2'd2},
    {8'h00,4'b0000,4'b0000,3'b100, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h04,4'b0011,4'b0001,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h04,4'b0011,4'b0001,3'b100, 1'b1,4'b1111,1'b0,2'd0},
    {8'h04,4'b0011,4'b0001,3'b100, 1'b1,4'b1101,1'b1,2'd1},
    {8'h04,4'b0011,4'b0001,3'b100, 1'b1,4'b1101,1'b1,2'd1},
    {8'h04,4'b0011,4'b0001,3'b110, 1'b1,4'b1101,1'b1,2'd1},
    {8'h04,4'b0001,4'b0001,3'b100, 1'b0,4'b1111,1'b0,2'd0},
    {8'h04,4'b0001,4'b0001,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h04,4'b0001,4'b0001,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h04,4'b0001,4'b0001,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h80,4'b1000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h80,4'b1000,4'b0000,3'b100, 1'b1,4'b1111,1'b0,2'd0},
    {8'h80,4'b1000,4'b0000,3'b100, 1'b1,4'b0111,1'b1,2'd3},
    {8'h80,4'b0000,4'b0000,3'b100, 1'b1,4'b0111,1'b0,2'd0},
    {8'h80,4'b0000,4'b0000,3'b100, 1'b0,4'b1111,1'b0,2'd0},
    {8'h80,4'b0000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h01,4'b0001,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h01,4'b0001,4'b0000,3'b100, 1'b1,4'b1111,1'b0,2'd0},
    {8'h01,4'b0001,4'b0000,3'b100, 1'b1,4'b1110,1'b1,2'd0},
    {8'h01,4'b0001,4'b0000,3'b000, 1'b1,4'b1111,1'b0,2'd0},
    {8'h01,4'b0001,4'b0000,3'b000, 1'b1,4'b1111,1'b0,2'd0},
    {8'h01,4'b0001,4'b0000,3'b100, 1'b1,4'b1111,1'b0,2'd0},
    {8'h01,4'b0001,4'b0000,3'b101, 1'b1,4'b1110,1'b1,2'd0},
    {8'h01,4'b0000,4'b0000,3'b100, 1'b0,4'b1111,1'b0,2'd0},
    {8'h01,4'b0000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0100,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0000,4'b0000,3'b000, 1'b1,4'b1111,1'b0,2'd0},
    {8'h00,4'b0000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0},
    {8'h00,4'b0000,4'b0000,3'b000, 1'b0,4'b1111,1'b0,2'd0}
  };

  function automatic string req_of(int k);
    if (k < 13)      return "R2 R3 R5 R6 R9";
    else if (k < 22) return "R4 R7 R9";
    else if (k < 28) return "R8";
    else if (k < 37) return "R10 R7";
    else             return "R11";
  endfunction

  task automatic check_out(string req, logic e_hrq, logic [3:0] e_dack,
                           logic e_stb, logic [1:0] e_chan);
    logic ok;
    ok = (hrq === e_hrq) && (dack_n === e_dack) && (xfer_stb === e_stb) &&
         (!e_stb || (xfer_chan === e_chan));
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got hrq=%b dack_n=%b stb=%b chan=%0d, expected hrq=%b dack_n=%b stb=%b chan=%0d",
               req, hrq, dack_n, xfer_stb, xfer_chan, e_hrq, e_dack, e_stb, e_chan);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check_out("R1 reset", 1'b0, 4'b1111, 1'b0, 2'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      chan_mode = VEC[k][26:19];
      dreq      = VEC[k][18:15];
      chan_mask = VEC[k][14:11];
      hlda      = VEC[k][10];
      tc        = VEC[k][9];
      eop_ext   = VEC[k][8];
      #1 check_out(req_of(k), VEC[k][7], VEC[k][6:3], VEC[k][2], VEC[k][1:0]);
    end

    // R8: demand service on channel 2 closed by terminal count while dreq stays high
    @(negedge clk);
    chan_mode = 8'h20; dreq = 4'b0100; chan_mask = '0; hlda = 1'b1; tc = 1'b0; eop_ext = 1'b0;
    @(negedge clk);
    @(negedge clk);
    tc = 1'b1;
    #1 check_out("R8 demand strobe", 1'b1, 4'b1011, 1'b1, 2'd2);
    @(negedge clk);
    tc = 1'b0;
    #1 check_out("R8 tc ends demand", 1'b0, 4'b1111, 1'b0, 2'd0);
    hlda = 1'b0; dreq = '0;
    @(negedge clk);
    @(negedge clk);

    // R1: reset applied in the middle of a block grant on channel 2
    chan_mode = 8'h10; dreq = 4'b0100; hlda = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1 check_out("R7 block grant", 1'b1, 4'b1011, 1'b1, 2'd2);
    rst_n = 1'b0;
    #1 check_out("R1 reset mid-grant", 1'b0, 4'b1111, 1'b0, 2'd0);
    @(negedge clk);
    dreq = '0; hlda = 1'b0;
    #1 check_out("R1 held in reset", 1'b0, 4'b1111, 1'b0, 2'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule